// File: doc/BRIEF.md
# Disjoint Track Switch Block

This block sits where four routing channels cross in a programmable fabric: north, east, south and west. Each channel is a bus of `WIDTH` bidirectional tracks, ten by default. Each bidirectional bus is modelled as three vectors: an input, an output and an output enable. The switch is track-preserving. Track `i` of one side can only take its value from track `i` of one of the other three sides, so a net that enters a track stays on that track index.

Every output track has its own 2-bit select code. Code 0 leaves the track undriven. Codes 1, 2 and 3 forward the same track from the next side clockwise, the side opposite, and the third side clockwise. The clockwise order is N, E, S, W, back to N. The 80 select bits arrive serially on a configuration chain that is shared with neighbouring blocks. While the enable is high, bits shift through a shadow register. When the enable falls, the shadow register is copied into the active register in one step. The chain output feeds the next block in the chain.

The configuration port is a plain serial chain with no valid/ready handshake. Data moves on every clock edge at which the enable is high, and the chain has no back-pressure. The routing path is purely combinational.

Top module: `dsw_switch_top`

## Requirements
- R1: After reset, every output enable is low, every output track is 0, and `cfg_dout` is 0.
- R2: A track whose select code is 0 has its output enable low and its output at 0, whatever the inputs are.
- R3: Side indices are N=0, E=1, S=2, W=3. A nonzero code `c` on side `s` forwards the input of side `(s+c) mod 4`. For example, north code 1 takes east, code 2 takes south and code 3 takes west.
- R4: Output track `i` depends only on input track `i` of the other sides and on its own select code. Changes on any other track index have no effect on it.
- R5: While `cfg_en` is low, `cfg_din` is ignored: the shadow register, and therefore `cfg_dout`, stays unchanged.
- R6: A newly shifted configuration takes effect only at the first clock edge at which `cfg_en` is sampled low after having been sampled high. Until that edge the outputs follow the previous configuration.
- R7: Each clock edge with `cfg_en` high shifts the chain by one bit. `cfg_dout` presents the bit that was shifted in 80 enabled edges earlier, so a block downstream receives the stream unchanged.
- R8: In the 80-bit configuration word, the code for side `s`, track `i` occupies bits `[s*2*WIDTH + 2*i +: 2]`. The first bit shifted in ends up in bit 79.
- R9: An output enable is high exactly when its select code is nonzero, independent of the input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable; its falling edge commits the configuration |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output to the next block |
| n_in | input | WIDTH | North tracks as received |
| n_out | output | WIDTH | North tracks as driven |
| n_oe | output | WIDTH | North drive enables |
| e_in | input | WIDTH | East tracks as received |
| e_out | output | WIDTH | East tracks as driven |
| e_oe | output | WIDTH | East drive enables |
| s_in | input | WIDTH | South tracks as received |
| s_out | output | WIDTH | South tracks as driven |
| s_oe | output | WIDTH | South drive enables |
| w_in | input | WIDTH | West tracks as received |
| w_out | output | WIDTH | West tracks as driven |
| w_oe | output | WIDTH | West drive enables |

## Verification
The bench loads broadcast patterns in which each track has one source side and every other side pulls from it. Across the tracks these patterns use all three nonzero codes on every side. A rotated side order or an off-by-one field position would show up as the wrong neighbour's value on an output. A walking-one stimulus catches any cross-track leak, which would raise a bit on a track that should stay quiet. The bench reads the outputs partway through a load and again just before the enable falls. A design without the double buffer, or one that committed on the wrong edge, would show half-loaded routing at those points. The bench also streams one configuration out through `cfg_dout` while the next one goes in, which exposes a reversed or truncated chain. Every configuration is screened for two sides forwarding the same track to each other, because in a real fabric that would close a combinational loop.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;

  localparam int unsigned NUM_SIDES = 4;
  localparam int unsigned SEL_W     = 2;

  // Side reached by stepping clockwise from side s.
  function automatic int unsigned cw_side(input int unsigned s, input int unsigned step);
    return (s + step) % NUM_SIDES;
  endfunction

endpackage

// File: rtl/dsw_cfg_chain.sv
module dsw_cfg_chain #(
  parameter int unsigned NBITS = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  output logic             dout,
  output logic [NBITS-1:0] active
);

  logic [NBITS-1:0] shadow;
  logic             en_q;
  logic             commit;

  assign commit = en_q && !en;
  assign dout   = shadow[NBITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en;
      if (en) shadow <= {shadow[NBITS-2:0], din};
      if (commit) active <= shadow;
    end
  end

  // R5
  shadow_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(shadow));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active));

  // R6
  active_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (active == $past(shadow)));

  // R7
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (dout == $past(shadow[NBITS-2])));

endmodule

// File: rtl/dsw_track_sel.sv
module dsw_track_sel
  import dsw_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [2:0]       cand,   // cand[k] comes from the side k+1 steps clockwise
  output logic             out,
  output logic             oe
);

  always_comb begin
    unique case (sel)
      2'd1:    out = cand[0];
      2'd2:    out = cand[1];
      2'd3:    out = cand[2];
      default: out = 1'b0;
    endcase
    oe = (sel != '0);
  end

endmodule

// File: rtl/dsw_side_drv.sv
module dsw_side_drv
  import dsw_pkg::*;
#(
  parameter int unsigned WIDTH = 10
) (
  input  logic [SEL_W*WIDTH-1:0] sel_vec,
  input  logic [WIDTH-1:0]       cw1,
  input  logic [WIDTH-1:0]       cw2,
  input  logic [WIDTH-1:0]       cw3,
  output logic [WIDTH-1:0]       out,
  output logic [WIDTH-1:0]       oe
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_track
    dsw_track_sel u_sel (
      .sel  (sel_vec[i*SEL_W +: SEL_W]),
      .cand ({cw3[i], cw2[i], cw1[i]}),
      .out  (out[i]),
      .oe   (oe[i])
    );
  end

endmodule

// File: rtl/dsw_switch_top.sv
module dsw_switch_top
  import dsw_pkg::*;
#(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             cfg_dout,
  input  logic [WIDTH-1:0] n_in,
  output logic [WIDTH-1:0] n_out,
  output logic [WIDTH-1:0] n_oe,
  input  logic [WIDTH-1:0] e_in,
  output logic [WIDTH-1:0] e_out,
  output logic [WIDTH-1:0] e_oe,
  input  logic [WIDTH-1:0] s_in,
  output logic [WIDTH-1:0] s_out,
  output logic [WIDTH-1:0] s_oe,
  input  logic [WIDTH-1:0] w_in,
  output logic [WIDTH-1:0] w_out,
  output logic [WIDTH-1:0] w_oe
);

  localparam int unsigned SIDE_BITS = SEL_W * WIDTH;
  localparam int unsigned CFG_BITS  = NUM_SIDES * SIDE_BITS;

  logic [CFG_BITS-1:0]                active_cfg;
  logic [NUM_SIDES-1:0][WIDTH-1:0]    in_bus;
  logic [NUM_SIDES-1:0][WIDTH-1:0]    out_bus;
  logic [NUM_SIDES-1:0][WIDTH-1:0]    oe_bus;

  assign in_bus[SIDE_N] = n_in;
  assign in_bus[SIDE_E] = e_in;
  assign in_bus[SIDE_S] = s_in;
  assign in_bus[SIDE_W] = w_in;

  assign n_out = out_bus[SIDE_N];
  assign e_out = out_bus[SIDE_E];
  assign s_out = out_bus[SIDE_S];
  assign w_out = out_bus[SIDE_W];
  assign n_oe  = oe_bus[SIDE_N];
  assign e_oe  = oe_bus[SIDE_E];
  assign s_oe  = oe_bus[SIDE_S];
  assign w_oe  = oe_bus[SIDE_W];

  dsw_cfg_chain #(.NBITS(CFG_BITS)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_en),
    .din    (cfg_din),
    .dout   (cfg_dout),
    .active (active_cfg)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dsw_side_drv #(.WIDTH(WIDTH)) u_drv (
      .sel_vec (active_cfg[s*SIDE_BITS +: SIDE_BITS]),
      .cw1     (in_bus[(s+1) % NUM_SIDES]),
      .cw2     (in_bus[(s+2) % NUM_SIDES]),
      .cw3     (in_bus[(s+3) % NUM_SIDES]),
      .out     (out_bus[s]),
      .oe      (oe_bus[s])
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_trk
      // R4
      track_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(in_bus[(s+1) % NUM_SIDES][i]) && $stable(in_bus[(s+2) % NUM_SIDES][i]) &&
         $stable(in_bus[(s+3) % NUM_SIDES][i]) &&
         $stable(active_cfg[s*SIDE_BITS + i*SEL_W +: SEL_W]))
        |-> $stable(out_bus[s][i]));
    end
  end

  // R9
  oe_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(active_cfg) |-> $stable(oe_bus));

endmodule

// File: tb/dsw_switch_top_tb_top.sv
module dsw_switch_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam int NCFG       = 4 * 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic cfg_dout;
  logic [3:0][W-1:0] in_b = '0;
  logic [3:0][W-1:0] out_b;
  logic [3:0][W-1:0] oe_b;
  logic [W-1:0] n_out, e_out, s_out, w_out, n_oe, e_oe, s_oe, w_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsw_switch_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .n_in(in_b[0]), .n_out(n_out), .n_oe(n_oe),
    .e_in(in_b[1]), .e_out(e_out), .e_oe(e_oe),
    .s_in(in_b[2]), .s_out(s_out), .s_oe(s_oe),
    .w_in(in_b[3]), .w_out(w_out), .w_oe(w_oe)
  );

  assign out_b[0] = n_out; assign out_b[1] = e_out;
  assign out_b[2] = s_out; assign out_b[3] = w_out;
  assign oe_b[0]  = n_oe;  assign oe_b[1]  = e_oe;
  assign oe_b[2]  = s_oe;  assign oe_b[3]  = w_oe;

  function automatic logic [1:0] code_of(input logic [NCFG-1:0] c, input int s, input int i);
    return c[s*2*W + 2*i +: 2];
  endfunction

  function automatic logic [W-1:0] exp_out(input logic [NCFG-1:0] c, input logic [3:0][W-1:0] ins, input int s);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      int cd = int'(code_of(c, s, i));
      if (cd != 0) r[i] = ins[(s + cd) % 4][i];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_oe(input logic [NCFG-1:0] c, input int s);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) r[i] = (code_of(c, s, i) != 2'd0);
    return r;
  endfunction

  // Each track gets one source side; every other side pulls from it.
  function automatic logic [NCFG-1:0] bcast(input int shift);
    logic [NCFG-1:0] c = '0;
    for (int i = 0; i < W; i++) begin
      int src = (i + shift) % 4;
      for (int s = 0; s < 4; s++)
        if (s != src) c[s*2*W + 2*i +: 2] = 2'((src - s + 4) % 4);
    end
    return c;
  endfunction

  function automatic bit has_mutual(input logic [NCFG-1:0] c);
    for (int i = 0; i < W; i++)
      for (int s = 0; s < 4; s++) begin
        int cs = int'(code_of(c, s, i));
        if (cs != 0) begin
          int t  = (s + cs) % 4;
          int ct = int'(code_of(c, t, i));
          if (ct != 0 && (t + ct) % 4 == s) return 1'b1;
        end
      end
    return 1'b0;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [NCFG-1:0] act, input logic [NCFG-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [NCFG-1:0] c);
    for (int s = 0; s < 4; s++) begin
      check_vec({req, " out"}, NCFG'(out_b[s]), NCFG'(exp_out(c, in_b, s)));
      check_vec({req, " oe"},  NCFG'(oe_b[s]),  NCFG'(exp_oe(c, s)));
    end
  endtask

  task automatic set_inputs(input logic [3:0][W-1:0] v);
    @(negedge clk);
    in_b = v;
    #1;
  endtask

  task automatic shift_bits(input logic [NCFG-1:0] c, input int hi, input int lo);
    for (int k = hi; k >= lo; k--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = c[k];
    end
  endtask

  task automatic commit_cfg();
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic load_cfg(input logic [NCFG-1:0] c);
    check_bit("R3 loop-free config", has_mutual(c), 1'b0);
    shift_bits(c, NCFG-1, 0);
    commit_cfg();
  endtask

  task automatic t_reset();
    #1;
    check_bit("R1 dout", cfg_dout, 1'b0);
    check_all("R1 reset", '0);
  endtask

  task automatic t_zero_cfg();
    set_inputs({10'h3FF, 10'h2AA, 10'h155, 10'h3FF});
    load_cfg('0);
    check_all("R2 all-zero codes", '0);
  endtask

  task automatic t_clockwise();
    for (int sh = 0; sh < 4; sh++) begin
      logic [NCFG-1:0] c = bcast(sh);
      load_cfg(c);
      set_inputs({10'h0F0, 10'h2AA, 10'h155, 10'h30C});
      check_all("R3 clockwise mapping", c);
      set_inputs({10'h10F, 10'h0D5, 10'h32A, 10'h0F3});
      check_all("R3 clockwise mapping", c);
    end
  endtask

  task automatic t_track_isolation();
    logic [NCFG-1:0] c = bcast(1);
    load_cfg(c);
    for (int j = 0; j < W; j++) begin
      logic [3:0][W-1:0] v;
      for (int s = 0; s < 4; s++) v[s] = W'(1) << j;
      set_inputs(v);
      check_all("R4 walking one", c);
    end
  endtask

  task automatic t_layout();
    logic [NCFG-1:0] c = '0;
    c[3*2*W + 2*7 +: 2] = 2'd2;   // west, track 7, opposite side (east)
    load_cfg(c);
    set_inputs({10'h000, 10'h000, 10'h080, 10'h000});
    check_bit("R8 west track7 oe", w_oe[7], 1'b1);
    check_bit("R8 west track7 value", w_out[7], 1'b1);
    check_bit("R8 only one oe", ($countones({n_oe, e_oe, s_oe, w_oe}) == 1), 1'b1);
    check_all("R8 single field", c);
  endtask

  task automatic t_oe_indep();
    logic [NCFG-1:0] c = bcast(3) & {NCFG/2{2'b11}} & ~(NCFG'({2*W{1'b1}}) << (2*W));
    load_cfg(c);
    set_inputs('0);
    check_all("R9 oe with zero inputs", c);
    set_inputs({4{10'h3FF}});
    check_all("R9 oe with one inputs", c);
    check_all("R2 masked side stays floating", c);
  endtask

  task automatic t_idle_ignore();
    logic [NCFG-1:0] c = bcast(2);
    logic d0;
    load_cfg(c);
    d0 = cfg_dout;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_din = k[0];
    end
    #1;
    check_bit("R5 dout held with enable low", cfg_dout, d0);
    check_all("R5 routing held with enable low", c);
  endtask

  task automatic t_double_buffer();
    logic [NCFG-1:0] a = bcast(0);
    logic [NCFG-1:0] b = bcast(1);
    load_cfg(a);
    set_inputs({10'h1C7, 10'h2B4, 10'h0E9, 10'h35A});
    shift_bits(b, NCFG-1, NCFG/2);
    #1;
    check_all("R6 half-loaded keeps old", a);
    shift_bits(b, NCFG/2-1, 0);
    #1;
    check_all("R6 fully shifted before fall keeps old", a);
    commit_cfg();
    check_all("R6 new config after fall", b);
  endtask

  task automatic t_scan_out();
    logic [NCFG-1:0] a = bcast(2);
    logic [NCFG-1:0] b = bcast(3);
    logic [NCFG-1:0] cap = '0;
    load_cfg(a);
    for (int k = NCFG-1; k >= 0; k--) begin
      @(negedge clk);
      cap[k]  = cfg_dout;
      cfg_en  = 1'b1;
      cfg_din = b[k];
    end
    commit_cfg();
    check_vec("R7 scan-out stream", cap, a);
    check_all("R7 following config active", b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_zero_cfg();
    t_clockwise();
    t_track_isolation();
    t_layout();
    t_oe_indep();
    t_idle_ignore();
    t_double_buffer();
    t_scan_out();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule